// File: doc/BRIEF.md
# SPI interrupt flag and status register block

This block collects the event pulses of an SPI engine with transmit and receive FIFOs and holds them as sticky flags that software reads through a 16-bit read-only status register. Three flags report interrupts: a byte-mode transmit event, a byte-mode receive event and a block-mode transfer-complete event. A fourth flag records a FIFO fault, either a transmit FIFO underflow or a receive FIFO overflow. Software tells the two apart by reading the flag together with the FIFO empty and full bits, which sit in a separate control register.

Software acknowledges the transmit and transfer flags by writing ones to a 16-bit write-only clear register. The clear bits act only in the cycle of the write. The receive flag clears when the receive FIFO is popped and that pop leaves it empty. The FIFO fault flag clears only on a FIFO-initialise strobe. The interrupt output is the OR of the three interrupt flags, each gated by its own enable. The fault flag is found by polling the status register and does not drive the interrupt output.

Top module: `spi_irq_status`

## Requirements
- R1: While reset is asserted and right after it is released, the status register reads 0 and irq_o is 0.
- R2: Read address 0 returns the status register. Its bit 7 is the FIFO fault flag, bit 2 the receive flag, bit 1 the transmit flag and bit 0 the transfer flag. Bits 15..8 and 6..3 read 0. Read address 1 (the clear register) and every other address return 0.
- R3: A transmit byte event sets status bit 1 on the next cycle. A write to address 1 with data bit 1 set clears it on the next cycle.
- R4: A transfer-complete event sets status bit 0 on the next cycle. A write to address 1 with data bit 0 set clears it on the next cycle.
- R5: A receive byte event sets status bit 2. The flag clears only in a cycle where the receive FIFO is popped and reports empty. Writing to the clear register has no effect on it.
- R6: An underflow or overflow pulse sets status bit 7. The flag holds until fifo_init_i, which clears it on the next cycle.
- R7: When a set event and a clear for the same flag occur in the same cycle, the flag is set.
- R8: Data bits 15..2 of a clear-register write have no effect. Writes to address 0 (status) or any other address have no effect. A clear write leaves no state behind, so a later event sets the flag again.
- R9: irq_o equals (transmit flag AND irq_en_tx_i) OR (receive flag AND irq_en_rx_i) OR (transfer flag AND irq_en_xfer_i). The FIFO fault flag never drives irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_tx_byte_i | input | 1 | Byte-mode transmit interrupt pulse |
| evt_rx_byte_i | input | 1 | Byte-mode receive interrupt pulse |
| evt_xfer_done_i | input | 1 | Block-mode transfer-complete pulse |
| evt_tx_underflow_i | input | 1 | Transmit FIFO underflow pulse |
| evt_rx_overflow_i | input | 1 | Receive FIFO overflow pulse |
| rx_pop_i | input | 1 | Receive FIFO read strobe |
| rx_empty_i | input | 1 | Receive FIFO empty after the current pop |
| fifo_init_i | input | 1 | FIFO-initialise strobe |
| irq_en_tx_i | input | 1 | Transmit interrupt enable |
| irq_en_rx_i | input | 1 | Receive interrupt enable |
| irq_en_xfer_i | input | 1 | Transfer interrupt enable |
| reg_raddr_i | input | ADDR_W | Read word address |
| reg_rdata_o | output | DATA_W | Read data |
| reg_wr_i | input | 1 | Write strobe |
| reg_waddr_i | input | ADDR_W | Write word address |
| reg_wdata_i | input | DATA_W | Write data |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a set event and a clear for the same flag in the same cycle, along with the ordering of a clear write, a later event and a pop that leaves the FIFO not empty. A pseudo-random sweep over several tens of thousands of cycles drives events sparsely, so the flags spend long stretches both set and clear. It mixes clear writes with junk upper data bits, writes to the status address, pops with and without empty, and all enable combinations. An arithmetic flag model in the bench predicts the read data and interrupt every cycle. Directed steps before the sweep force each contention case on its own.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int unsigned NUM_FLAGS = 4;

  typedef enum logic [1:0] {
    FL_XFER = 2'd0,
    FL_TX   = 2'd1,
    FL_RX   = 2'd2,
    FL_ERR  = 2'd3
  } flag_e;

  // status bit position of each flag index
  function automatic int unsigned flag_bit(input int unsigned idx);
    case (idx)
      0:       return 0;
      1:       return 1;
      2:       return 2;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/spi_stat_flag.sv
module spi_stat_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  // set has priority so no event is dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= 1'b0;
    else if (set_i) q_q <= 1'b1;
    else if (clr_i) q_q <= 1'b0;
  end

  assign q_o = q_q;
endmodule

// File: rtl/spi_stat_wdec.sv
module spi_stat_wdec #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CLR_ADDR = 1
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [1:0]        wbits_i,
  output logic              clr_tx_o,
  output logic              clr_xfer_o
);
  logic hit;

  assign hit        = wr_i && (waddr_i == ADDR_W'(CLR_ADDR));
  assign clr_tx_o   = hit && wbits_i[1];
  assign clr_xfer_o = hit && wbits_i[0];
endmodule

// File: rtl/spi_stat_rmux.sv
module spi_stat_rmux
  import spi_stat_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned STAT_ADDR = 0
) (
  input  logic [NUM_FLAGS-1:0] flags_i,
  input  logic [ADDR_W-1:0]    raddr_i,
  output logic [DATA_W-1:0]    status_o,
  output logic [DATA_W-1:0]    rdata_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic v;
    always_comb begin
      v = 1'b0;
      for (int unsigned f = 0; f < NUM_FLAGS; f++) begin
        if (flag_bit(f) == b) v = flags_i[f];
      end
    end
    assign status_o[b] = v;
  end

  assign rdata_o = (raddr_i == ADDR_W'(STAT_ADDR)) ? status_o : '0;
endmodule

// File: rtl/spi_stat_irq.sv
module spi_stat_irq
  import spi_stat_pkg::*;
(
  input  logic [NUM_FLAGS-1:0] flags_i,
  input  logic                 en_tx_i,
  input  logic                 en_rx_i,
  input  logic                 en_xfer_i,
  output logic                 irq_o
);
  logic [NUM_FLAGS-1:0] en;

  // fault flag is poll-only
  assign en[FL_XFER] = en_xfer_i;
  assign en[FL_TX]   = en_tx_i;
  assign en[FL_RX]   = en_rx_i;
  assign en[FL_ERR]  = 1'b0;

  assign irq_o = |(flags_i & en);
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_stat_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned STAT_ADDR = 0,
  parameter int unsigned CLR_ADDR  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_tx_byte_i,
  input  logic              evt_rx_byte_i,
  input  logic              evt_xfer_done_i,
  input  logic              evt_tx_underflow_i,
  input  logic              evt_rx_overflow_i,
  input  logic              rx_pop_i,
  input  logic              rx_empty_i,
  input  logic              fifo_init_i,
  input  logic              irq_en_tx_i,
  input  logic              irq_en_rx_i,
  input  logic              irq_en_xfer_i,
  input  logic [ADDR_W-1:0] reg_raddr_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_waddr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic              irq_o
);
  logic [NUM_FLAGS-1:0] set_v, clr_v, flags;
  logic [DATA_W-1:0]    status_w;
  logic                 clr_tx, clr_xfer;
  logic                 unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:2];

  spi_stat_wdec #(.ADDR_W(ADDR_W), .CLR_ADDR(CLR_ADDR)) u_wdec (
    .wr_i      (reg_wr_i),
    .waddr_i   (reg_waddr_i),
    .wbits_i   (reg_wdata_i[1:0]),
    .clr_tx_o  (clr_tx),
    .clr_xfer_o(clr_xfer)
  );

  assign set_v[FL_XFER] = evt_xfer_done_i;
  assign set_v[FL_TX]   = evt_tx_byte_i;
  assign set_v[FL_RX]   = evt_rx_byte_i;
  assign set_v[FL_ERR]  = evt_tx_underflow_i | evt_rx_overflow_i;

  assign clr_v[FL_XFER] = clr_xfer;
  assign clr_v[FL_TX]   = clr_tx;
  assign clr_v[FL_RX]   = rx_pop_i & rx_empty_i;
  assign clr_v[FL_ERR]  = fifo_init_i;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    spi_stat_flag u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_v[g]),
      .clr_i (clr_v[g]),
      .q_o   (flags[g])
    );
  end

  spi_stat_rmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_ADDR(STAT_ADDR)) u_rmux (
    .flags_i (flags),
    .raddr_i (reg_raddr_i),
    .status_o(status_w),
    .rdata_o (reg_rdata_o)
  );

  spi_stat_irq u_irq (
    .flags_i  (flags),
    .en_tx_i  (irq_en_tx_i),
    .en_rx_i  (irq_en_rx_i),
    .en_xfer_i(irq_en_xfer_i),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/spi_irq_status_chk.sv
module spi_irq_status_chk #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CLR_ADDR = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              evt_tx_byte_i,
  input logic              evt_rx_byte_i,
  input logic              evt_xfer_done_i,
  input logic              evt_tx_underflow_i,
  input logic              evt_rx_overflow_i,
  input logic              rx_pop_i,
  input logic              rx_empty_i,
  input logic              fifo_init_i,
  input logic              irq_en_tx_i,
  input logic              irq_en_rx_i,
  input logic              irq_en_xfer_i,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_waddr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] status_i,
  input logic              irq_o
);
  logic clr_hit;
  assign clr_hit = reg_wr_i && (reg_waddr_i == ADDR_W'(CLR_ADDR));

  assert_reserved_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[DATA_W-1:8] == '0) && (status_i[6:3] == '0));

  assert_tx_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_tx_byte_i |=> status_i[1]);

  assert_tx_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_hit && reg_wdata_i[1] && !evt_tx_byte_i) |=> !status_i[1]);

  assert_xfer_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_xfer_done_i |=> status_i[0]);

  assert_xfer_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_hit && reg_wdata_i[0] && !evt_xfer_done_i) |=> !status_i[0]);

  assert_rx_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[2] && !(rx_pop_i && rx_empty_i)) |=> status_i[2]);

  assert_rx_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_rx_byte_i |=> status_i[2]);

  assert_err_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_tx_underflow_i || evt_rx_overflow_i) |=> status_i[7]);

  assert_err_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[7] && !fifo_init_i) |=> status_i[7]);

  assert_irq_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_en_tx_i || irq_en_rx_i || irq_en_xfer_i) |-> !irq_o);

  assert_err_no_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[2:0] == 3'b000) |-> !irq_o);
endmodule

bind spi_irq_status spi_irq_status_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLR_ADDR(CLR_ADDR)
) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .evt_tx_byte_i     (evt_tx_byte_i),
  .evt_rx_byte_i     (evt_rx_byte_i),
  .evt_xfer_done_i   (evt_xfer_done_i),
  .evt_tx_underflow_i(evt_tx_underflow_i),
  .evt_rx_overflow_i (evt_rx_overflow_i),
  .rx_pop_i          (rx_pop_i),
  .rx_empty_i        (rx_empty_i),
  .fifo_init_i       (fifo_init_i),
  .irq_en_tx_i       (irq_en_tx_i),
  .irq_en_rx_i       (irq_en_rx_i),
  .irq_en_xfer_i     (irq_en_xfer_i),
  .reg_wr_i          (reg_wr_i),
  .reg_waddr_i       (reg_waddr_i),
  .reg_wdata_i       (reg_wdata_i),
  .status_i          (status_w),
  .irq_o             (irq_o)
);

// File: tb/test_spi_irq_status.sv
module test_spi_irq_status;
  localparam int CLK_PERIOD = 10;
  localparam int SWEEP      = 40000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        evt_tx = 0, evt_rx = 0, evt_xf = 0, evt_un = 0, evt_ov = 0;
  logic        pop = 0, empty = 0, init = 0;
  logic        en_tx = 0, en_rx = 0, en_xf = 0;
  logic [3:0]  raddr = 0, waddr = 0;
  logic        wr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0, errors = 0;
  logic m_tx = 0, m_rx = 0, m_xf = 0, m_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_irq_status i_spi_irq_status (
    .clk_i(clk), .rst_ni(rst_ni),
    .evt_tx_byte_i(evt_tx), .evt_rx_byte_i(evt_rx), .evt_xfer_done_i(evt_xf),
    .evt_tx_underflow_i(evt_un), .evt_rx_overflow_i(evt_ov),
    .rx_pop_i(pop), .rx_empty_i(empty), .fifo_init_i(init),
    .irq_en_tx_i(en_tx), .irq_en_rx_i(en_rx), .irq_en_xfer_i(en_xf),
    .reg_raddr_i(raddr), .reg_rdata_o(rdata),
    .reg_wr_i(wr), .reg_waddr_i(waddr), .reg_wdata_i(wdata),
    .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_rd();
    if (raddr == 4'd0) return {8'h00, m_err, 4'h0, m_rx, m_tx, m_xf};
    return 16'h0000;
  endfunction

  function automatic logic exp_irq();
    return (m_tx & en_tx) | (m_rx & en_rx) | (m_xf & en_xf);
  endfunction

  // one clock: update model from applied inputs, then check at negedge
  task automatic step(input string req);
    logic clr_hit;
    @(posedge clk);
    clr_hit = wr && (waddr == 4'd1);
    m_tx  = evt_tx | (m_tx & ~(clr_hit & wdata[1]));
    m_xf  = evt_xf | (m_xf & ~(clr_hit & wdata[0]));
    m_rx  = evt_rx | (m_rx & ~(pop & empty));
    m_err = evt_un | evt_ov | (m_err & ~init);
    @(negedge clk);
    chk(req, rdata, exp_rd());
    chk({req, " irq R9"}, {15'h0, irq}, {15'h0, exp_irq()});
  endtask

  task automatic idle();
    {evt_tx, evt_rx, evt_xf, evt_un, evt_ov, pop, empty, init, wr} = '0;
    wdata = 16'h0; waddr = 4'd0; raddr = 4'd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    en_tx = 1; en_rx = 1; en_xf = 1;
    repeat (2) @(negedge clk);
    chk("R1 in reset", rdata, 16'h0000);
    chk("R1 irq in reset", {15'h0, irq}, 16'h0);
    rst_ni = 1'b1;
    step("R1 after reset");

    // set every flag
    evt_tx = 1; evt_rx = 1; evt_xf = 1; evt_un = 1;
    step("R2 R3 R4 R5 R6 set");
    idle();
    chk("R2 layout", rdata, 16'h0087);
    raddr = 4'd1; #1; chk("R2 clear reg reads 0", rdata, 16'h0000);
    raddr = 4'd5; #1; chk("R2 unmapped reads 0", rdata, 16'h0000);
    raddr = 4'd0;

    // write to status address and junk upper bits are ignored
    wr = 1; waddr = 4'd0; wdata = 16'hFFFF; step("R8 write status ignored");
    wr = 1; waddr = 4'd1; wdata = 16'hFFFC; step("R8 upper bits ignored");
    chk("R5 R8 no write clear of rx", rdata, 16'h0087);
    // contention: set wins
    wr = 1; waddr = 4'd1; wdata = 16'h0003; evt_tx = 1; evt_xf = 1;
    step("R7 set beats clear");
    idle(); pop = 1; empty = 1; evt_rx = 1; init = 1; evt_ov = 1;
    step("R7 rx and err set beat clear");
    // real clears
    idle(); wr = 1; waddr = 4'd1; wdata = 16'h0002; step("R3 clear tx");
    idle(); wr = 1; waddr = 4'd1; wdata = 16'h0001; step("R4 clear xfer");
    idle(); pop = 1; empty = 0; step("R5 pop not empty keeps rx");
    idle(); pop = 1; empty = 1; step("R5 pop to empty clears rx");
    idle(); step("R6 err holds");
    chk("R6 err held", rdata, 16'h0080);
    en_tx = 1; en_rx = 1; en_xf = 1; #1;
    chk("R9 err alone no irq", {15'h0, irq}, 16'h0);
    init = 1; step("R6 init clears err");
    idle(); evt_tx = 1; step("R8 tx sets again after clear");
    idle();

    r = 32'h1234_5678;
    for (int i = 0; i < SWEEP; i++) begin
      r ^= r << 13; r ^= r >> 17; r ^= r << 5;
      evt_tx = r[0] & r[1];
      evt_rx = r[2] & r[3];
      evt_xf = r[4] & r[5];
      evt_un = r[6] & r[7] & r[8];
      evt_ov = r[9] & r[10] & r[11];
      init   = r[12] & r[13];
      pop    = r[14];
      empty  = r[15];
      wr     = r[16] | r[17];
      waddr  = r[18] ? 4'd1 : {r[19], 2'b00, r[20]};
      wdata  = {r[31:22] & {10{r[21]}}, 4'h0, r[23], r[24]};
      raddr  = r[25] ? 4'd0 : {r[26], r[27], 1'b0, r[28]};
      en_tx  = r[29]; en_rx = r[30]; en_xf = r[31];
      step("R2/R3/R4/R5/R6/R7/R8 sweep");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule